// File: doc/BRIEF.md
# Packed SIMD Shift and Logic Unit

This unit is a registered 64-bit datapath stage. It combines a destination operand and a source operand under an operation select. Four of the operations are bitwise logic operations on the whole 64-bit word. The other three are shifts applied to packed lanes.

For the shifts, the destination operand is cut into lanes of 16, 32 or 64 bits, chosen by a lane-size select. Every lane is shifted by the same unsigned 8-bit count. Each lane fills its own vacated bits, with zeros or with copies of its sign bit, and no bit moves from one lane into another.

Operation and lane-size combinations that have no meaning raise an illegal flag and force the result to zero. The result and the flag appear one clock after the operands are presented.

Top module: `simd_shift_logic`

## Requirements
- R1: Operation code 0 returns dst AND src, code 2 returns dst OR src, and code 3 returns dst XOR src, each bitwise across all 64 bits.
- R2: Operation code 1 (and-not) returns the inverted destination ANDed with the source, that is ~dst & src.
- R3: Operation code 4 is a logical left shift of each lane of dst by the count. Vacated low bits are zero and no bit crosses a lane boundary. Lane-size code 0 selects 16-bit lanes, code 1 selects 32-bit lanes and code 2 selects one 64-bit lane.
- R4: Operation code 5 is a logical right shift of each lane of dst by the count, with the vacated high bits of each lane set to zero.
- R5: Operation code 6 is an arithmetic right shift of each 16-bit or 32-bit lane. It copies each lane's own top bit into that lane's vacated high bits.
- R6: For operation codes 4 and 5, a count equal to or larger than the lane width gives an all-zero lane.
- R7: For operation code 6, a count equal to or larger than the lane width fills every bit of each lane with that lane's sign bit.
- R8: The following combinations are illegal: operation code 6 with lane-size code 2, any shift (codes 4 to 6) with lane-size code 3, and operation code 7. For each of them, illegal_o is 1 and result_o is all zeros.
- R9: The logic operations (codes 0 to 3) ignore both the lane-size select and the count. They never raise illegal_o, even with lane-size code 3.
- R10: result_o and illegal_o are registered and reflect the inputs sampled at the previous rising clock edge. An active-low asynchronous reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dst_i | input | 64 | Destination operand; this is the value that is shifted |
| src_i | input | 64 | Source operand for the logic operations |
| count_i | input | 8 | Unsigned shift count, shared by all lanes |
| op_i | input | 3 | Operation select (codes 0 to 7, see requirements) |
| lane_i | input | 2 | Lane size: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 = reserved |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Registered flag for an illegal operation and lane-size combination |

## Verification
The only state in the unit is the output register, so any internal fault shows at the ports in the cycle after the offending operands are sampled. A wrong lane-size decode shows up as bits leaking across a 16-bit or 32-bit boundary, or as fill bits in the wrong position. The bench targets the counts at the lane edges (0, width-1, width, 255) and random operands with set sign bits, so that fill errors are visible in every lane. The illegal decode is driven through every reserved combination, and logic operations are also sent with the reserved lane size.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int unsigned DATA_W  = 64;
    localparam int unsigned COUNT_W = 8;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_ANDN = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_SLL  = 3'd4,
        OP_SRL  = 3'd5,
        OP_SRA  = 3'd6,
        OP_RSVD = 3'd7
    } simd_op_e;

    typedef enum logic [1:0] {
        LANE_16   = 2'd0,
        LANE_32   = 2'd1,
        LANE_64   = 2'd2,
        LANE_RSVD = 2'd3
    } lane_sel_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2,
        SH_NONE  = 2'd3
    } shift_kind_e;

endpackage

// File: rtl/simd_bitwise.sv
module simd_bitwise
    import simd_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  simd_op_e           op_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [WIDTH-1:0]   y_o
);

    always_comb begin
        unique case (op_i)
            OP_AND:  y_o = a_i & b_i;
            OP_ANDN: y_o = ~a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane_shift.sv
module simd_lane_shift
    import simd_pkg::*;
#(
    parameter int unsigned LANE_W = 16,
    parameter int unsigned CNT_W  = COUNT_W
) (
    input  shift_kind_e          kind_i,
    input  logic [LANE_W-1:0]    lane_i,
    input  logic [CNT_W-1:0]     cnt_i,
    output logic [LANE_W-1:0]    lane_o
);

    localparam int unsigned SH_W = $clog2(LANE_W);

    logic              over_w;
    logic [SH_W-1:0]   amt;
    logic              sign_bit;

    assign over_w   = (cnt_i >= CNT_W'(LANE_W));
    assign amt      = cnt_i[SH_W-1:0];
    assign sign_bit = lane_i[LANE_W-1];

    always_comb begin
        unique case (kind_i)
            SH_LEFT:  lane_o = over_w ? '0 : (lane_i << amt);
            SH_RLOG:  lane_o = over_w ? '0 : (lane_i >> amt);
            SH_RARI:  lane_o = over_w ? {LANE_W{sign_bit}}
                                      : $unsigned($signed(lane_i) >>> amt);
            default:  lane_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_packed_shift.sv
module simd_packed_shift
    import simd_pkg::*;
#(
    parameter int unsigned WIDTH  = DATA_W,
    parameter int unsigned LANE_W = 16,
    parameter int unsigned CNT_W  = COUNT_W
) (
    input  shift_kind_e         kind_i,
    input  logic [WIDTH-1:0]    data_i,
    input  logic [CNT_W-1:0]    cnt_i,
    output logic [WIDTH-1:0]    data_o
);

    localparam int unsigned N_LANES = WIDTH / LANE_W;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        simd_lane_shift #(
            .LANE_W (LANE_W),
            .CNT_W  (CNT_W)
        ) u_lane (
            .kind_i (kind_i),
            .lane_i (data_i[g*LANE_W +: LANE_W]),
            .cnt_i  (cnt_i),
            .lane_o (data_o[g*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/simd_shift_logic.sv
module simd_shift_logic
    import simd_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    parameter int unsigned CNT_W = COUNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   dst_i,
    input  logic [WIDTH-1:0]   src_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [2:0]         op_i,
    input  logic [1:0]         lane_i,
    output logic [WIDTH-1:0]   result_o,
    output logic               illegal_o
);

    localparam int unsigned N_SIZES = 3;

    simd_op_e     op;
    lane_sel_e    lane;
    shift_kind_e  kind;
    logic         is_shift;
    logic         bad_combo;

    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] shift_res [N_SIZES];
    logic [WIDTH-1:0] next_res;

    assign op   = simd_op_e'(op_i);
    assign lane = lane_sel_e'(lane_i);

    always_comb begin
        unique case (op)
            OP_SLL:  kind = SH_LEFT;
            OP_SRL:  kind = SH_RLOG;
            OP_SRA:  kind = SH_RARI;
            default: kind = SH_NONE;
        endcase
    end

    assign is_shift  = (kind != SH_NONE);
    assign bad_combo = (op == OP_RSVD)
                     || (is_shift && lane == LANE_RSVD)
                     || (op == OP_SRA && lane == LANE_64);

    simd_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .op_i (op),
        .a_i  (dst_i),
        .b_i  (src_i),
        .y_o  (logic_res)
    );

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        simd_packed_shift #(
            .WIDTH  (WIDTH),
            .LANE_W (16 << s),
            .CNT_W  (CNT_W)
        ) u_shift (
            .kind_i (kind),
            .data_i (dst_i),
            .cnt_i  (count_i),
            .data_o (shift_res[s])
        );
    end

    always_comb begin
        if (bad_combo) begin
            next_res = '0;
        end else if (is_shift) begin
            unique case (lane)
                LANE_16: next_res = shift_res[0];
                LANE_32: next_res = shift_res[1];
                LANE_64: next_res = shift_res[2];
                default: next_res = '0;
            endcase
        end else begin
            next_res = logic_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o  <= '0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= next_res;
            illegal_o <= bad_combo;
        end
    end

endmodule

// File: rtl/simd_shift_logic_chk.sv
module simd_shift_logic_chk #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned CNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [WIDTH-1:0]   dst_i,
    input logic [WIDTH-1:0]   src_i,
    input logic [CNT_W-1:0]   count_i,
    input logic [2:0]         op_i,
    input logic [1:0]         lane_i,
    input logic [WIDTH-1:0]   result_o,
    input logic               illegal_o
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (result_o == '0));

    a_r8_sra64_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i == 3'd6 && lane_i == 2'd2)) |-> illegal_o);

    a_r9_logic_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i < 3'd4)) |-> !illegal_o);

    a_r1_xor_word: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i == 3'd3)) |-> (result_o == $past(dst_i ^ src_i)));

    a_r2_andn_word: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i == 3'd1)) |-> (result_o == $past(~dst_i & src_i)));

    a_r6_logical_big: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past((op_i == 3'd4 || op_i == 3'd5) && lane_i != 2'd3
                         && count_i >= CNT_W'(64))) |-> (result_o == '0));

    a_r7_sra16_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i == 3'd6 && lane_i == 2'd0 && count_i >= CNT_W'(16)))
        |-> (result_o[15:0] == {16{$past(dst_i[15])}}));

endmodule

bind simd_shift_logic simd_shift_logic_chk #(
    .WIDTH (WIDTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dst_i     (dst_i),
    .src_i     (src_i),
    .count_i   (count_i),
    .op_i      (op_i),
    .lane_i    (lane_i),
    .result_o  (result_o),
    .illegal_o (illegal_o)
);

// File: tb/simd_shift_logic_bench.sv
`timescale 1ns/1ps
module simd_shift_logic_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dst_i = '0;
    logic [63:0] src_i = '0;
    logic [7:0]  count_i = '0;
    logic [2:0]  op_i = '0;
    logic [1:0]  lane_i = '0;
    logic [63:0] result_o;
    logic        illegal_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    simd_shift_logic u_simd_shift_logic (
        .clk       (clk),
        .rst_n     (rst_n),
        .dst_i     (dst_i),
        .src_i     (src_i),
        .count_i   (count_i),
        .op_i      (op_i),
        .lane_i    (lane_i),
        .result_o  (result_o),
        .illegal_o (illegal_o)
    );

    function automatic logic exp_illegal(input logic [2:0] op, input logic [1:0] ln);
        if (op == 3'd7) return 1'b1;
        if (op >= 3'd4 && ln == 2'd3) return 1'b1;
        if (op == 3'd6 && ln == 2'd2) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [63:0] exp_result(input logic [2:0] op, input logic [1:0] ln,
                                               input logic [63:0] d, input logic [63:0] s,
                                               input logic [7:0] c);
        logic [63:0] acc;
        int w;
        logic [63:0] mask;
        if (exp_illegal(op, ln)) return '0;
        case (op)
            3'd0: return d & s;
            3'd1: return ~d & s;
            3'd2: return d | s;
            3'd3: return d ^ s;
            default: ;
        endcase
        w = 16 << ln;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        acc = '0;
        for (int base = 0; base < 64; base += w) begin
            logic [63:0] x;
            logic [63:0] y;
            logic sgn;
            x = (d >> base) & mask;
            sgn = x[w-1];
            if (op == 3'd4)      y = (int'(c) >= w) ? '0 : ((x << c) & mask);
            else if (op == 3'd5) y = (int'(c) >= w) ? '0 : (x >> c);
            else begin
                if (int'(c) >= w) y = sgn ? mask : '0;
                else y = (x >> c) | (sgn ? (mask & ~(mask >> c)) : '0);
            end
            acc |= (y << base);
        end
        return acc;
    endfunction

    function automatic string req_of(input logic [2:0] op, input logic [1:0] ln, input logic [7:0] c);
        if (exp_illegal(op, ln)) return "R8";
        case (op)
            3'd1: return "R2";
            3'd0, 3'd2, 3'd3: return (ln == 2'd3) ? "R9" : "R1";
            3'd4: return (int'(c) >= (16 << ln)) ? "R6" : "R3";
            3'd5: return (int'(c) >= (16 << ln)) ? "R6" : "R4";
            default: return (int'(c) >= (16 << ln)) ? "R7" : "R5";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [1:0] ln,
                          input logic [63:0] d, input logic [63:0] s, input logic [7:0] c);
        logic [63:0] er;
        logic ei;
        @(negedge clk);
        op_i = op; lane_i = ln; dst_i = d; src_i = s; count_i = c;
        er = exp_result(op, ln, d, s, c);
        ei = exp_illegal(op, ln);
        @(negedge clk);
        n_cmp++;
        if (result_o !== er || illegal_o !== ei) begin
            n_bad++;
            $display("FAIL %s op=%0d lane=%0d cnt=%0d: got %h/%b expected %h/%b",
                     req_of(op, ln, c), op, ln, c, result_o, illegal_o, er, ei);
        end
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        // R10: reset state
        n_cmp++;
        if (result_o !== '0 || illegal_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: got %h/%b expected 0/0", result_o, illegal_o);
        end
        rst_n = 1'b1;

        // R1 / R2 directed
        run_op(3'd0, 2'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FFFF, 8'd0);
        run_op(3'd1, 2'd1, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FFFF, 8'd3);
        run_op(3'd2, 2'd2, 64'h8000_0000_0000_0001, 64'h0000_0001_8000_0000, 8'd9);
        run_op(3'd3, 2'd0, 64'hAAAA_5555_AAAA_5555, 64'hFFFF_FFFF_0000_0000, 8'd1);
        // R9: logic with reserved lane and large count
        run_op(3'd3, 2'd3, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 8'd255);
        run_op(3'd1, 2'd3, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'd77);

        // R3..R7 boundary counts per lane size
        for (int ln = 0; ln < 3; ln++) begin
            int w;
            w = 16 << ln;
            for (int op = 4; op < 7; op++) begin
                if (op == 6 && ln == 2) continue;
                run_op(3'(op), 2'(ln), 64'h8001_7FFE_C003_4005, '0, 8'd0);
                run_op(3'(op), 2'(ln), 64'h8001_7FFE_C003_4005, '0, 8'(w-1));
                run_op(3'(op), 2'(ln), 64'h8001_7FFE_C003_4005, '0, 8'(w));
                run_op(3'(op), 2'(ln), 64'h8001_7FFE_C003_4005, '0, 8'd255);
                run_op(3'(op), 2'(ln), 64'hFFFF_FFFF_FFFF_FFFF, '0, 8'd1);
            end
        end

        // R8: every illegal combination
        run_op(3'd6, 2'd2, 64'h8000_0000_0000_0000, '1, 8'd4);
        run_op(3'd4, 2'd3, '1, '1, 8'd1);
        run_op(3'd5, 2'd3, '1, '1, 8'd1);
        run_op(3'd6, 2'd3, '1, '1, 8'd1);
        run_op(3'd7, 2'd0, '1, '1, 8'd0);
        run_op(3'd7, 2'd3, '1, '1, 8'd0);

        // Random mix covering R1..R9; back-to-back exercises R10 latency
        for (int i = 0; i < 600; i++) begin
            logic [63:0] d;
            logic [63:0] s;
            logic [7:0] c;
            d = {$urandom(), $urandom()};
            s = {$urandom(), $urandom()};
            c = ($urandom() % 4 == 0) ? 8'($urandom()) : 8'($urandom() % 70);
            run_op(3'($urandom() % 8), 2'($urandom() % 4), d, s, c);
        end

        // R10: reset mid-run clears the registered outputs
        run_op(3'd7, 2'd0, '1, '1, 8'd0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        n_cmp++;
        if (result_o !== '0 || illegal_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 async reset: got %h/%b expected 0/0", result_o, illegal_o);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule